// File: doc/BRIEF.md
# Virtual Interrupt Completion and Deactivation Unit

This unit completes virtual interrupts that are held in a small bank of list entries. A guest issues one of two completion commands. The end-of-interrupt command always asks an external active-priority tracker to drop the running priority. The deactivate command only removes the active state. Each list entry holds:

- a virtual ID,
- a physical ID,
- a priority,
- a group bit,
- a hardware-linked flag,
- an active bit.

A hypervisor-side load port writes these entries. Only the first `used_cnt` entries take part in a search.

A mode input chooses how the two commands share the work. In combined mode, an end-of-interrupt both drops priority and deactivates, and a deactivate command is ignored. In split mode, an end-of-interrupt only drops priority, and deactivation comes from the deactivate command. When a deactivation finds no matching active entry, a wrapping completion-miss counter is incremented instead. When the deactivated entry is hardware-linked, its physical ID is forwarded for one cycle on a physical-deactivate output.

Top module: `eoi_unit`

## Requirements
- R1: After reset, all entry active bits, the miss counter `eoi_count` and `pdeact_valid` are 0.
- R2: `drop_req` is 1 in every cycle where `cmd_valid`=1 and `cmd_dir`=0 (end-of-interrupt), whatever the ID or mode, and 0 otherwise.
- R3: A command whose ID is 8192 or above never clears an active bit, never pulses `pdeact_valid` and never changes `eoi_count`.
- R4: With `eoi_mode`=0 (combined), a deactivate command (`cmd_dir`=1) has no effect on the active bits, `eoi_count` or `pdeact_valid`.
- R5: With `eoi_mode`=1 (split), an end-of-interrupt only raises `drop_req`. It clears no active bit and leaves `eoi_count` unchanged.
- R6: The search looks only at entries with index below `used_cnt`. It takes the lowest-indexed entry whose virtual ID equals `cmd_vid` and whose active bit is set. Later duplicates keep their active bit.
- R7: When a deactivation is due and no entry matches, `eoi_count` increments by one on the next clock edge. It is 5 bits wide and wraps from 31 to 0.
- R8: In combined mode, an end-of-interrupt deactivates the matched entry only if two conditions hold. Otherwise it is ignored. The conditions are:
  - the entry's group equals `cmd_grp`;
  - the entry's preemption value equals `drop_prio`. The preemption value is the priority ANDed with `0xFF << s`, where s = `bpr0`+1 for group 0 and s = `bpr1` for group 1.
- R9: A deactivation clears the matched entry's active bit on the next clock edge.
- R10: A deactivation of a hardware-linked entry drives `pdeact_valid`=1 with `pdeact_id` = the entry's physical ID for exactly the cycle after the command. A deactivation of an entry without the link leaves `pdeact_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load one list entry |
| ld_idx | input | 2 | Entry index to load |
| ld_vid | input | 16 | Virtual ID to load |
| ld_pid | input | 10 | Physical ID to load |
| ld_prio | input | 8 | Priority to load |
| ld_grp | input | 1 | Group to load |
| ld_hw | input | 1 | Hardware-linked flag to load |
| ld_act | input | 1 | Active bit to load |
| used_cnt | input | 3 | Number of entries taking part in a search |
| eoi_mode | input | 1 | 0 combined, 1 split |
| bpr0 | input | 3 | Group 0 binary point |
| bpr1 | input | 3 | Group 1 binary point |
| cmd_valid | input | 1 | Completion command present |
| cmd_dir | input | 1 | 0 end-of-interrupt, 1 deactivate |
| cmd_grp | input | 1 | Group of the end-of-interrupt |
| cmd_vid | input | 16 | Virtual ID being completed |
| drop_req | output | 1 | Priority-drop request to the tracker |
| drop_prio | input | 8 | Priority returned by the tracker in the same cycle |
| pdeact_valid | output | 1 | Physical deactivate pulse |
| pdeact_id | output | 10 | Physical ID being deactivated |
| eoi_count | output | 5 | Completion-miss counter |
| lr_active | output | 4 | Active bit of each entry |

## Verification
The bench uses four entries: an inactive decoy, an active target, an active duplicate of the target and an active entry in the LPI range. With this set, the first-match rule, the used-count bound and the LPI cutoff can all be seen at `lr_active`.

The bench sweeps every combination of the following, with both hardware-link settings of the target and the entries reloaded for each trial:
- mode;
- command kind;
- ID class (hit, miss, LPI);
- command group;
- tracker priority (matching or not).

A final run of misses pushes the 5-bit counter past its wrap point.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
  parameter int VID_W  = 16;
  parameter int PID_W  = 10;
  parameter int PRIO_W = 8;

  typedef struct packed {
    logic [VID_W-1:0]  vid;
    logic [PID_W-1:0]  pid;
    logic [PRIO_W-1:0] prio;
    logic              grp;
    logic              hw;
  } lr_entry_t;
endpackage

// File: rtl/lr_bank.sv
module lr_bank
  import eoi_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDX_W = $clog2(NUM_LR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  lr_entry_t        ld_data,
  input  logic             ld_act,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output lr_entry_t        ent [NUM_LR],
  output logic [NUM_LR-1:0] act
);
  lr_entry_t         ent_q [NUM_LR];
  logic [NUM_LR-1:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (clr_en) act_d[clr_idx] = 1'b0;
    if (ld_en)  act_d[ld_idx]  = ld_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  for (genvar i = 0; i < NUM_LR; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (ld_en && ld_idx == IDX_W'(i)) ent_q[i] <= ld_data;
    end
    assign ent[i] = ent_q[i];
  end

  assign act = act_q;

  // R9
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_q & ~$past(act_q)) != '0) |-> $past(ld_en));
  // R6
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_en) |-> ($countones($past(act_q) & ~act_q) <= 1));
endmodule

// File: rtl/lr_match.sv
module lr_match
  import eoi_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDX_W = $clog2(NUM_LR),
  localparam int CNT_W = $clog2(NUM_LR + 1)
) (
  input  lr_entry_t         ent [NUM_LR],
  input  logic [NUM_LR-1:0] act,
  input  logic [CNT_W-1:0]  used_cnt,
  input  logic [VID_W-1:0]  key,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [NUM_LR-1:0] cand;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_cmp
    assign cand[i] = (CNT_W'(i) < used_cnt) && act[i] && (ent[i].vid == key);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_LR - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/eoi_ctrl.sv
module eoi_ctrl
  import eoi_pkg::*;
#(
  parameter int LPI_BASE = 8192,
  parameter int MISS_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_dir,
  input  logic              cmd_grp,
  input  logic [VID_W-1:0]  cmd_vid,
  input  logic              eoi_mode,
  input  logic [2:0]        bpr0,
  input  logic [2:0]        bpr1,
  input  logic              hit,
  input  lr_entry_t         hit_ent,
  input  logic [PRIO_W-1:0] drop_prio,
  output logic              drop_req,
  output logic              do_deact,
  output logic              pdeact_valid,
  output logic [PID_W-1:0]  pdeact_id,
  output logic [MISS_W-1:0] miss_cnt
);
  logic              is_lpi, want_deact, do_bump, ok_eoi;
  logic [3:0]        shamt;
  logic [PRIO_W-1:0] pre;
  logic              pv_d;
  logic [PID_W-1:0]  pid_d;
  logic [MISS_W-1:0] cnt_d, cnt_q;
  logic              pv_q;
  logic [PID_W-1:0]  pid_q;

  always_comb begin
    is_lpi   = cmd_vid >= VID_W'(LPI_BASE);
    drop_req = cmd_valid && !cmd_dir;
    shamt    = hit_ent.grp ? {1'b0, bpr1} : ({1'b0, bpr0} + 4'd1);
    pre      = hit_ent.prio & (PRIO_W'({PRIO_W{1'b1}}) << shamt);
    ok_eoi   = (hit_ent.grp == cmd_grp) && (pre == drop_prio);
    want_deact = cmd_valid && !is_lpi && (cmd_dir == eoi_mode);
    do_bump  = want_deact && !hit;
    do_deact = want_deact && hit && (cmd_dir || ok_eoi);
    pv_d     = do_deact && hit_ent.hw;
    pid_d    = pv_d ? hit_ent.pid : '0;
    cnt_d    = do_bump ? cnt_q + MISS_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pv_q  <= 1'b0;
      pid_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pv_q  <= pv_d;
      pid_q <= pid_d;
    end
  end

  assign miss_cnt     = cnt_q;
  assign pdeact_valid = pv_q;
  assign pdeact_id    = pid_q;

  // R7
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + MISS_W'(1)));
  // R10
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> $past(cmd_valid));
  // R3
  lpi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_lpi) |=> (!pv_q && $stable(cnt_q)));
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_deact, do_bump}));
endmodule

// File: rtl/eoi_unit.sv
module eoi_unit
  import eoi_pkg::*;
#(
  parameter int NUM_LR   = 4,
  parameter int LPI_BASE = 8192,
  parameter int MISS_W   = 5,
  localparam int IDX_W   = $clog2(NUM_LR),
  localparam int CNT_W   = $clog2(NUM_LR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [VID_W-1:0]  ld_vid,
  input  logic [PID_W-1:0]  ld_pid,
  input  logic [PRIO_W-1:0] ld_prio,
  input  logic              ld_grp,
  input  logic              ld_hw,
  input  logic              ld_act,
  input  logic [CNT_W-1:0]  used_cnt,
  input  logic              eoi_mode,
  input  logic [2:0]        bpr0,
  input  logic [2:0]        bpr1,
  input  logic              cmd_valid,
  input  logic              cmd_dir,
  input  logic              cmd_grp,
  input  logic [VID_W-1:0]  cmd_vid,
  output logic              drop_req,
  input  logic [PRIO_W-1:0] drop_prio,
  output logic              pdeact_valid,
  output logic [PID_W-1:0]  pdeact_id,
  output logic [MISS_W-1:0] eoi_count,
  output logic [NUM_LR-1:0] lr_active
);
  logic              rs_meta, rs_q;
  lr_entry_t         ld_data;
  lr_entry_t         ent [NUM_LR];
  logic [NUM_LR-1:0] act;
  logic              hit, do_deact;
  logic [IDX_W-1:0]  hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_q    <= rs_meta;
    end
  end

  assign ld_data = '{vid: ld_vid, pid: ld_pid, prio: ld_prio, grp: ld_grp, hw: ld_hw};

  lr_bank #(.NUM_LR(NUM_LR)) u_bank (
    .clk(clk), .rst_n(rs_q), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .ld_act(ld_act), .clr_en(do_deact),
    .clr_idx(hit_idx), .ent(ent), .act(act)
  );

  lr_match #(.NUM_LR(NUM_LR)) u_match (
    .ent(ent), .act(act), .used_cnt(used_cnt), .key(cmd_vid),
    .hit(hit), .hit_idx(hit_idx)
  );

  eoi_ctrl #(.LPI_BASE(LPI_BASE), .MISS_W(MISS_W)) u_ctrl (
    .clk(clk), .rst_n(rs_q), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_grp(cmd_grp), .cmd_vid(cmd_vid), .eoi_mode(eoi_mode),
    .bpr0(bpr0), .bpr1(bpr1), .hit(hit), .hit_ent(ent[hit_idx]),
    .drop_prio(drop_prio), .drop_req(drop_req), .do_deact(do_deact),
    .pdeact_valid(pdeact_valid), .pdeact_id(pdeact_id), .miss_cnt(eoi_count)
  );

  assign lr_active = act;

  // R4
  combined_dir_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (cmd_valid && cmd_dir && !eoi_mode && !ld_en) |=> (lr_active == $past(lr_active)));
  // R5
  split_eoi_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (cmd_valid && !cmd_dir && eoi_mode && !ld_en) |=> (lr_active == $past(lr_active) && $stable(eoi_count)));
endmodule

// File: tb/eoi_unit_test.sv
module eoi_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en, ld_grp, ld_hw, ld_act;
  logic [1:0]  ld_idx;
  logic [15:0] ld_vid, cmd_vid;
  logic [9:0]  ld_pid;
  logic [7:0]  ld_prio, drop_prio;
  logic [2:0]  used_cnt, bpr0, bpr1;
  logic        eoi_mode, cmd_valid, cmd_dir, cmd_grp;
  logic        drop_req, pdeact_valid;
  logic [9:0]  pdeact_id;
  logic [4:0]  eoi_count;
  logic [3:0]  lr_active;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eoi_unit uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input int vid, input int pid, input int prio,
                      input bit grp, input bit hw, input bit a);
    @(negedge clk);
    ld_en = 1; ld_idx = 2'(idx); ld_vid = 16'(vid); ld_pid = 10'(pid);
    ld_prio = 8'(prio); ld_grp = grp; ld_hw = hw; ld_act = a;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic setup(input bit hw);
    load(0, 10, 5, 8'h46, 1, 0, 0);
    load(1, 10, 10'h2A5, 8'h46, 1, hw, 1);
    load(2, 10, 7, 8'h46, 1, 1, 1);
    load(3, 8200, 9, 8'h10, 0, 1, 1);
  endtask

  // Issue one command; check drop_req in its cycle (R2), return to negedge after edge.
  task automatic issue(input bit dir, input bit grp, input int vid, input int dprio);
    cmd_valid = 1; cmd_dir = dir; cmd_grp = grp; cmd_vid = 16'(vid); drop_prio = 8'(dprio);
    #1;
    chk("R2", drop_req, !dir);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cnt_exp = 0;
    rst_n = 0; ld_en = 0; ld_idx = 0; ld_vid = 0; ld_pid = 0; ld_prio = 0;
    ld_grp = 0; ld_hw = 0; ld_act = 0; used_cnt = 4; eoi_mode = 0;
    bpr0 = 1; bpr1 = 2; cmd_valid = 0; cmd_dir = 0; cmd_grp = 0; cmd_vid = 0; drop_prio = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1", lr_active, 0); chk("R1", eoi_count, 0); chk("R1", pdeact_valid, 0);
    chk("R2", drop_req, 0);

    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 2; k++)
        for (int v = 0; v < 3; v++)
          for (int g = 0; g < 2; g++)
            for (int p = 0; p < 2; p++)
              for (int h = 0; h < 2; h++) begin
                int vid, dprio;
                bit want, deact, bump;
                setup(h[0]);
                chk("R6", lr_active, 4'b1110);
                eoi_mode = m[0];
                vid   = (v == 0) ? 10 : (v == 1) ? 99 : 8200;
                dprio = (p == 0) ? 8'h44 : 8'h40;
                // R3 R4 R5: deactivation due only in matching mode and below LPI base
                want  = (v != 2) && (k == m);
                bump  = want && (v == 1);
                // R8: combined EOI needs group 1 and preemption 0x46&0xFC=0x44
                deact = want && (v == 0) && (k == 1 || (g == 1 && p == 0));
                issue(k[0], g[0], vid, dprio);
                if (bump) cnt_exp = (cnt_exp + 1) % 32;
                // R6 R9: only entry 1 cleared, duplicate in entry 2 kept
                chk(v == 2 ? "R3" : (k == 1 && m == 0) ? "R4" : (k == 0 && m == 1) ? "R5" : "R9",
                    lr_active, deact ? 4'b1100 : 4'b1110);
                chk(bump ? "R7" : "R8", eoi_count, cnt_exp);
                // R10
                chk("R10", pdeact_valid, deact && h == 1);
                if (deact && h == 1) chk("R10", pdeact_id, 10'h2A5);
                @(negedge clk);
                chk("R10", pdeact_valid, 0);
              end

    // R6: entry 0 only in use, it is inactive -> miss
    setup(1);
    used_cnt = 1; eoi_mode = 1;
    issue(1, 1, 10, 0);
    cnt_exp = (cnt_exp + 1) % 32;
    chk("R6", lr_active, 4'b1110);
    chk("R6", eoi_count, cnt_exp);
    used_cnt = 4;

    // R7: wrap of the miss counter
    for (int i = 0; i < 20; i++) begin
      issue(1, 0, 1234, 0);
      cnt_exp = (cnt_exp + 1) % 32;
      chk("R7", eoi_count, cnt_exp);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule